// File: doc/BRIEF.md
# Block-Counted Mask Reseed Pacer

This block decides when the pseudo-random generator that feeds a masked cipher datapath must take on fresh entropy. A small rate code sets how many data blocks may be processed between two reseeds. A down-counter tracks how many blocks remain before the current seed is used up. The counter is already used up after reset, so the very first block always asks for a reseed.

The cipher control logic pulses `blk_start` when it wants to begin a block. If the counter has run out at that moment, the pacer raises `reseed_req`. The control logic must not proceed with that block until the generator pulses `reseed_done`. At that point the pacer drops the request and reloads the counter for the selected rate, with the waiting block already counted. While a fatal alert is present, no new request is made and any pending request is withdrawn.

Top module: `reseed_pacer`

## Requirements
- R1: After a synchronous active-low reset, `reseed_req` is 0 and `ctr_expired` is 1.
- R2: A `blk_start` pulse while `ctr_expired` is 1 and `fatal_alert` is 0 sets `reseed_req` on the next cycle. The request then stays at 1 until a `reseed_done` pulse is accepted or `fatal_alert` rises.
- R3: Rate code 3'b001 makes every block request a reseed. After each completed reseed, `ctr_expired` reads 1 again.
- R4: Rate code 3'b010 requests a reseed on one block in every 64.
- R5: Rate code 3'b100 requests a reseed on one block in every 8192.
- R6: The rate codes 3'b000, 3'b011, 3'b101, 3'b110 and 3'b111 all behave exactly like 3'b001.
- R7: An accepted `reseed_done` loads N-1, where N is the period (1, 64 or 8192). Each later `blk_start` lowers the count by one. `ctr_expired` is 1 exactly when the count is zero, that is, after the N-1 blocks that follow a reseed.
- R8: While `fatal_alert` is 1, no reseed request is raised. A pending request drops to 0 on the next cycle, and a later `reseed_done` pulse does not reload the counter.
- R9: A `reseed_done` pulse that arrives while no request is pending has no effect on the count.
- R10: While a request is pending, further `blk_start` pulses are ignored.
- R11: The rate code is sampled only when a reseed completes. Changing it between reseeds does not alter the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 3 | One-hot reseed rate code |
| blk_start | input | 1 | One-cycle pulse: a new data block wants to begin |
| reseed_done | input | 1 | One-cycle pulse: the generator has taken fresh entropy |
| fatal_alert | input | 1 | Fatal alert; suppresses reseeding while high |
| reseed_req | output | 1 | Reseed request to the generator; the block start waits on it |
| ctr_expired | output | 1 | Block counter has reached zero |

## Verification
A count that is wrong by even one shows up as `ctr_expired` at the wrong block, and as a request one block early or late. This is visible on the first block at which the count should have reached zero: at most 64 blocks into a 3'b010 period, or 8192 into a 3'b100 period. A request flag that is stuck or cleared by mistake shows up in the cycle after the `blk_start` or `reseed_done` that should have changed it. Sweeping every rate code, including the illegal ones, catches faults in the decode that only certain codes would expose.

// File: rtl/reseed_pacer_pkg.sv
// Package: shared rate code type and reload helper for the reseed pacer.
// Assumes the rate code is one-hot; any other value is treated as per-block.
package reseed_pacer_pkg;

    typedef enum logic [2:0] {
        RATE_EACH = 3'b001,
        RATE_MID  = 3'b010,
        RATE_SLOW = 3'b100
    } rate_code_e;

    // Map a raw code onto a legal one, folding illegal codes to per-block.
    function automatic rate_code_e legalize_rate(input logic [2:0] code);
        rate_code_e res;
        case (code)
            3'b010:  res = RATE_MID;
            3'b100:  res = RATE_SLOW;
            default: res = RATE_EACH;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/reseed_rate_decode.sv
// Module: turns the raw rate code into the counter reload value (period - 1).
// Assumes MID_LOG2 <= SLOW_LOG2 and CTR_W >= SLOW_LOG2. Purely combinational.
module reseed_rate_decode
    import reseed_pacer_pkg::*;
#(
    parameter int MID_LOG2  = 6,
    parameter int SLOW_LOG2 = 13,
    parameter int CTR_W     = SLOW_LOG2
) (
    input  logic [2:0]       rate_sel,
    output logic [CTR_W-1:0] reload_val
);
    localparam logic [CTR_W-1:0] MID_RELOAD  = CTR_W'((64'd1 << MID_LOG2) - 64'd1);
    localparam logic [CTR_W-1:0] SLOW_RELOAD = CTR_W'((64'd1 << SLOW_LOG2) - 64'd1);

    rate_code_e code_legal;

    // Fold the code to a legal one and select the matching reload value.
    always_comb begin
        code_legal = legalize_rate(rate_sel);
        case (code_legal)
            RATE_MID:  reload_val = MID_RELOAD;
            RATE_SLOW: reload_val = SLOW_RELOAD;
            default:   reload_val = '0;
        endcase
    end
endmodule

// File: rtl/reseed_block_counter.sv
// Module: saturating down-counter of blocks that remain before the next reseed.
// Assumes load and dec are never both high; load wins if they are.
// Resets to zero, which means "expired".
module reseed_block_counter #(
    parameter int CTR_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CTR_W-1:0] load_val,
    input  logic             dec,
    output logic             expired
);
    logic [CTR_W-1:0] cnt_q;

    // Reload on a completed reseed, otherwise count blocks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CTR_W'(1);
        end
    end

    // The counter is expired when it has reached zero.
    always_comb expired = (cnt_q == '0);
endmodule

// File: rtl/reseed_req_ctrl.sv
// Module: holds the reseed request and derives the counter strobes.
// Assumes blk_start and reseed_done are single-cycle pulses.
// A fatal alert blocks new requests and drops a pending one.
module reseed_req_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_start,
    input  logic reseed_done,
    input  logic fatal_alert,
    input  logic expired,
    output logic reseed_req,
    output logic ctr_load,
    output logic ctr_dec
);
    logic req_q;
    logic req_set;

    // Decode the request-set, reload and decrement conditions.
    always_comb begin
        req_set  = blk_start && !req_q && expired && !fatal_alert;
        ctr_load = req_q && reseed_done && !fatal_alert;
        ctr_dec  = blk_start && !req_q && !expired;
    end

    // Request register: cleared by a fatal alert or an accepted done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (fatal_alert || ctr_load) begin
            req_q <= 1'b0;
        end else if (req_set) begin
            req_q <= 1'b1;
        end
    end

    // Drive the request straight from the register.
    always_comb reseed_req = req_q;
endmodule

// File: rtl/reseed_pacer.sv
// Module: top of the block-counted reseed pacer.
// Assumes the cipher control waits on reseed_req before starting a block.
module reseed_pacer #(
    parameter int MID_LOG2  = 6,
    parameter int SLOW_LOG2 = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_sel,
    input  logic       blk_start,
    input  logic       reseed_done,
    input  logic       fatal_alert,
    output logic       reseed_req,
    output logic       ctr_expired
);
    localparam int CTR_W = SLOW_LOG2;

    logic [CTR_W-1:0] reload_val;
    logic             ctr_load;
    logic             ctr_dec;
    logic             expired;

    reseed_rate_decode #(
        .MID_LOG2  (MID_LOG2),
        .SLOW_LOG2 (SLOW_LOG2),
        .CTR_W     (CTR_W)
    ) u_decode (
        .rate_sel   (rate_sel),
        .reload_val (reload_val)
    );

    reseed_block_counter #(
        .CTR_W (CTR_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (reload_val),
        .dec      (ctr_dec),
        .expired  (expired)
    );

    reseed_req_ctrl u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_start   (blk_start),
        .reseed_done (reseed_done),
        .fatal_alert (fatal_alert),
        .expired     (expired),
        .reseed_req  (reseed_req),
        .ctr_load    (ctr_load),
        .ctr_dec     (ctr_dec)
    );

    // Export the expired flag.
    always_comb ctr_expired = expired;
endmodule

// File: rtl/reseed_pacer_chk.sv
// Module: port-level property checker, bound to every reseed_pacer instance.
module reseed_pacer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] rate_sel,
    input logic       blk_start,
    input logic       reseed_done,
    input logic       fatal_alert,
    input logic       reseed_req,
    input logic       ctr_expired
);
    // R2: a pending request is held until it is done or aborted.
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_req && !reseed_done && !fatal_alert |=> reseed_req);

    // R2: a request only rises after a block start seen while expired.
    a_r2_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reseed_req) |-> $past(blk_start) && $past(ctr_expired));

    // R8: a fatal alert leaves no request in the next cycle.
    a_r8_fatal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_alert |=> !reseed_req);

    // R10: the count stays at zero while a request is pending.
    a_r10_pending_expired: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_req |-> ctr_expired);

    // R7: an accepted done pulse clears the request.
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_req && reseed_done && !fatal_alert |=> !reseed_req);

    // R3: the per-block rate (and the illegal codes, R6) leaves the counter expired after a reseed.
    a_r3_per_block: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_req && reseed_done && !fatal_alert
        && rate_sel != 3'b010 && rate_sel != 3'b100 |=> ctr_expired);
endmodule

bind reseed_pacer reseed_pacer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .blk_start   (blk_start),
    .reseed_done (reseed_done),
    .fatal_alert (fatal_alert),
    .reseed_req  (reseed_req),
    .ctr_expired (ctr_expired)
);

// File: tb/reseed_pacer_tb.sv
module reseed_pacer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'b001;
    logic       blk_start = 1'b0;
    logic       reseed_done = 1'b0;
    logic       fatal_alert = 1'b0;
    logic       reseed_req;
    logic       ctr_expired;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    reseed_pacer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel    (rate_sel),
        .blk_start   (blk_start),
        .reseed_done (reseed_done),
        .fatal_alert (fatal_alert),
        .reseed_req  (reseed_req),
        .ctr_expired (ctr_expired)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        blk_start = 1'b0; reseed_done = 1'b0; fatal_alert = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic start_block();
        @(negedge clk) blk_start = 1'b1;
        @(negedge clk) blk_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk) reseed_done = 1'b1;
        @(negedge clk) reseed_done = 1'b0;
    endtask

    // Run nblk blocks from reset with a fixed code; period is per_n.
    task automatic run_rate(input logic [2:0] code, input int per_n, input int nblk,
                            input string tag);
        do_reset();
        rate_sel = code;
        for (int i = 0; i < nblk; i++) begin
            start_block();
            chk(reseed_req, (i % per_n) == 0, tag);
            if ((i % per_n) == 0) begin
                pulse_done();
                chk(reseed_req, 1'b0, tag);
                chk(ctr_expired, per_n == 1, "R7");
            end else begin
                chk(ctr_expired, (i % per_n) == per_n - 1, "R7");
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk(reseed_req, 1'b0, "R1");
        chk(ctr_expired, 1'b1, "R1");

        // R2 and R10: request is held and extra starts are ignored
        rate_sel = 3'b010;
        start_block();
        chk(reseed_req, 1'b1, "R2");
        repeat (5) @(negedge clk);
        chk(reseed_req, 1'b1, "R2");
        start_block();
        start_block();
        chk(reseed_req, 1'b1, "R10");
        pulse_done();
        chk(reseed_req, 1'b0, "R2");
        chk(ctr_expired, 1'b0, "R10");
        for (int i = 1; i < 64; i++) begin
            start_block();
            chk(reseed_req, 1'b0, "R10");
        end
        chk(ctr_expired, 1'b1, "R10");
        start_block();
        chk(reseed_req, 1'b1, "R10");

        // R3, R4, R5: legal rates
        run_rate(3'b001, 1, 8, "R3");
        run_rate(3'b010, 64, 130, "R4");
        run_rate(3'b100, 8192, 8194, "R5");

        // R6: illegal codes fold to per-block
        run_rate(3'b000, 1, 4, "R6");
        run_rate(3'b011, 1, 4, "R6");
        run_rate(3'b101, 1, 4, "R6");
        run_rate(3'b110, 1, 4, "R6");
        run_rate(3'b111, 1, 4, "R6");

        // R9: stray done pulses leave the count alone
        do_reset();
        rate_sel = 3'b010;
        start_block();
        pulse_done();
        for (int i = 0; i < 10; i++) start_block();
        repeat (3) pulse_done();
        chk(reseed_req, 1'b0, "R9");
        chk(ctr_expired, 1'b0, "R9");
        for (int i = 0; i < 52; i++) start_block();
        chk(ctr_expired, 1'b0, "R9");
        start_block();
        chk(ctr_expired, 1'b1, "R9");
        start_block();
        chk(reseed_req, 1'b1, "R9");

        // R11: a rate change between reseeds does not alter the count
        do_reset();
        rate_sel = 3'b010;
        start_block();
        pulse_done();
        rate_sel = 3'b001;
        for (int i = 1; i < 64; i++) begin
            start_block();
            chk(reseed_req, 1'b0, "R11");
        end
        start_block();
        chk(reseed_req, 1'b1, "R11");
        pulse_done();
        chk(ctr_expired, 1'b1, "R11");

        // R8: fatal alert suppresses and aborts reseeds
        do_reset();
        rate_sel = 3'b001;
        fatal_alert = 1'b1;
        start_block();
        chk(reseed_req, 1'b0, "R8");
        chk(ctr_expired, 1'b1, "R8");
        fatal_alert = 1'b0;
        start_block();
        chk(reseed_req, 1'b1, "R8");
        @(negedge clk) fatal_alert = 1'b1;
        @(negedge clk);
        chk(reseed_req, 1'b0, "R8");
        rate_sel = 3'b010;
        pulse_done();
        chk(ctr_expired, 1'b1, "R8");
        fatal_alert = 1'b0;
        start_block();
        chk(reseed_req, 1'b1, "R8");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule